// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked on-chip request bus and an external 16-bit asynchronous static RAM with 20 word-address bits. It accepts one read or write per request over a valid/ready handshake. It then plays out the RAM's control sequence, using cycle counters to meet each nanosecond minimum. A read returns its data with a one-cycle valid pulse. A write returns a one-cycle done pulse.

Every phase length is derived from a clock-period parameter and from separate nanosecond limits. The count is the rounded-up quotient, and never less than one cycle. The address, the byte enables and the data pins belong to the request that was accepted.

The RAM has two chip selects: one active low and one active high. It also has an active-low output enable, an active-low write enable and two active-low byte-lane enables. A write ends on the rising edge of the write enable while the chip select and the byte enables stay asserted. Every read is followed by a gap with the RAM deselected, so that its drivers reach high impedance before the controller can drive the bus.

The data bus is presented as three separate signals: an output value, a drive enable and an input value. The pad ring combines them into a tristate bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, and whenever the block is idle, these pins are inactive: the low-active select is high, the high-active select is low, both lane enables are high, the output enable is high and the write enable is high. In the same states the data bus is not driven and `reqReady` is high.
- R2: `reqReady` is high only while idle. A request is taken on a clock edge where `reqValid` and `reqReady` are both high. While an access is in progress `reqReady` stays low, and a request presented during that time has no effect on the pins.
- R3: A read holds both selects active, the output enable low and the write enable high for N_RD cycles. N_RD is the largest of ceil(tRC/P), ceil(tAA/P) and ceil(tOE/P); it is 6 at the default P = 10 ns. The address and lane enables stay constant throughout.
- R4: Read data is sampled on the edge that ends the last output-enable-low cycle. `rdValid` is then high for exactly one cycle, carrying that data.
- R5: A write has three phases, all with both selects active, the output enable high and the address constant:
  - one setup cycle with the write enable high;
  - N_PWE cycles with the write enable low, where N_PWE = max(ceil(tPWE/P), ceil(tAW/P)-1, ceil(tSD/P)-1), which is 4 by default;
  - N_HOLD = max(1, ceil(tWC/P)-1-N_PWE) cycles with the write enable high, which is 1 by default.
- R6: The data bus is driven with the request's write data only during the setup cycle, the write-enable-low cycles and the first cycle after the write enable rises. It is released at all other times.
- R7: `wrDone` is high for exactly one cycle, in the first idle cycle after a write.
- R8: After each read there are N_TURN = ceil(tHZ/P) cycles, 2 by default, in which:
  - the chip is deselected and the output enable is high;
  - the data bus is not driven;
  - `reqReady` is low.
- R9: Mask bit 0 selects data bits 7:0 and mask bit 1 selects data bits 15:8. The lane enable pin for a lane is low only when its mask bit is set. A write changes only the selected lanes, and a write with mask 00 leaves memory unchanged. In read data, lanes whose mask bit is clear read as zero.
- R10: The output enable is never low while the write enable is low or while the controller drives the data bus.
- R11: The write enable rises while both selects are still active and the lane enables are unchanged, so the write ends on the write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 20 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Byte lane mask, bit 0 = low byte |
| rdValid | output | 1 | One-cycle read data strobe |
| rdData | output | 16 | Read data, unselected lanes zero |
| wrDone | output | 1 | One-cycle write completion strobe |
| ramAddr | output | 20 | RAM word address |
| ramSelN | output | 1 | Active-low chip select |
| ramSelP | output | 1 | Active-high chip select |
| ramLaneN | output | 2 | Active-low byte lane enables, bit 0 = low byte |
| ramOutEnN | output | 1 | Active-low output enable |
| ramWrEnN | output | 1 | Active-low write enable |
| ramDqOut | output | 16 | Data value driven toward the RAM |
| ramDqDrive | output | 1 | Drive enable for the data bus |
| ramDqIn | input | 16 | Data value seen on the RAM bus |

## Verification
The hardest state to reach from the ports is a request that arrives while an access is still in progress. It should be held off without disturbing the address or lanes of the running write. To reach it, the bench raises `reqValid` with a conflicting read in the middle of one write pulse and withdraws it before the controller goes idle. It then checks that the pins, the memory and the idle cycle that follows are unchanged. The bench also sweeps all four byte masks for writes and for read-back over sixteen addresses, using a RAM model on the bench side. That model returns a filler pattern on disabled lanes and flags any bus conflict.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } ctrlState_t;

  // Strobes from control to datapath. Pin strobes describe the next cycle.
  typedef struct packed {
    logic load;     // latch the accepted request
    logic select;   // chips selected next cycle
    logic outEn;    // output enable low next cycle
    logic wrPulse;  // write enable low next cycle
    logic drive;    // data bus driven next cycle
    logic capture;  // sample read data at this edge
    logic wrEnd;    // write completes at this edge
  } ctrlStrobe_t;

  // Cycles needed to cover minNs at clkNs per cycle, at least one.
  function automatic int phaseCycles(input int minNs, input int clkNs);
    int c;
    c = (minNs + clkNs - 1) / clkNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int N_RD   = 6,
  parameter int N_PWE  = 4,
  parameter int N_HOLD = 1,
  parameter int N_TURN = 2,
  parameter int CNT_W  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output ctrlStrobe_t stb
);

  ctrlState_t       st, stNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             cntZero;

  assign cntZero  = (cnt == '0);
  assign reqReady = (st == ST_IDLE);

  always_comb begin
    stNxt       = st;
    cntNxt      = cnt;
    stb.load    = 1'b0;
    stb.capture = 1'b0;
    stb.wrEnd   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (reqValid) begin
          stb.load = 1'b1;
          if (reqWrite) begin
            stNxt  = ST_WSETUP;
            cntNxt = '0;
          end else begin
            stNxt  = ST_RD;
            cntNxt = CNT_W'(N_RD - 1);
          end
        end
      end
      ST_RD: begin
        if (cntZero) begin
          stb.capture = 1'b1;
          stNxt       = ST_TURN;
          cntNxt      = CNT_W'(N_TURN - 1);
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cntZero) stNxt = ST_IDLE;
        else         cntNxt = cnt - 1'b1;
      end
      ST_WSETUP: begin
        stNxt  = ST_WPULSE;
        cntNxt = CNT_W'(N_PWE - 1);
      end
      ST_WPULSE: begin
        if (cntZero) begin
          stNxt  = ST_WHOLD;
          cntNxt = CNT_W'(N_HOLD - 1);
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_WHOLD: begin
        if (cntZero) begin
          stNxt     = ST_IDLE;
          stb.wrEnd = 1'b1;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      default: stNxt = ST_IDLE;
    endcase

    stb.select  = stNxt inside {ST_RD, ST_WSETUP, ST_WPULSE, ST_WHOLD};
    stb.outEn   = (stNxt == ST_RD);
    stb.wrPulse = (stNxt == ST_WPULSE);
    // data held one cycle past the write enable rising edge
    stb.drive   = (stNxt inside {ST_WSETUP, ST_WPULSE})
                || (stNxt == ST_WHOLD && st == ST_WPULSE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNxt;
      cnt <= cntNxt;
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] ramDqIn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramSelN,
  output logic              ramSelP,
  output logic [LANES-1:0]  ramLaneN,
  output logic              ramOutEnN,
  output logic              ramWrEnN,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqDrive,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              wrDone
);

  logic [LANES-1:0] maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramAddr    <= '0;
      ramDqOut   <= '0;
      maskQ      <= '0;
      ramSelN    <= 1'b1;
      ramSelP    <= 1'b0;
      ramOutEnN  <= 1'b1;
      ramWrEnN   <= 1'b1;
      ramDqDrive <= 1'b0;
      rdValid    <= 1'b0;
      wrDone     <= 1'b0;
    end else begin
      if (stb.load) begin
        ramAddr  <= reqAddr;
        ramDqOut <= reqWdata;
        maskQ    <= reqMask;
      end
      ramSelN    <= !stb.select;
      ramSelP    <= stb.select;
      ramOutEnN  <= !stb.outEn;
      ramWrEnN   <= !stb.wrPulse;
      ramDqDrive <= stb.drive;
      rdValid    <= stb.capture;
      wrDone     <= stb.wrEnd;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       laneSel;
    logic       laneNQ;
    logic [7:0] rdByteQ;

    assign laneSel = stb.load ? reqMask[l] : maskQ[l];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneNQ  <= 1'b1;
        rdByteQ <= '0;
      end else begin
        laneNQ <= !(stb.select && laneSel);
        if (stb.capture) rdByteQ <= maskQ[l] ? ramDqIn[l*8 +: 8] : 8'h00;
      end
    end

    assign ramLaneN[l]       = laneNQ;
    assign rdData[l*8 +: 8]  = rdByteQ;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_OE_NS   = 25,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_AW_NS   = 40,
  parameter int T_SD_NS   = 25,
  parameter int T_HZ_NS   = 18,
  localparam int LANES    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              wrDone,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramSelN,
  output logic              ramSelP,
  output logic [LANES-1:0]  ramLaneN,
  output logic              ramOutEnN,
  output logic              ramWrEnN,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqDrive,
  input  logic [DATA_W-1:0] ramDqIn
);

  localparam int N_RD   = maxInt(phaseCycles(T_RC_NS, CLK_NS),
                                 maxInt(phaseCycles(T_AA_NS, CLK_NS),
                                        phaseCycles(T_OE_NS, CLK_NS)));
  // setup cycle already counts toward address and data setup
  localparam int N_PWE  = maxInt(phaseCycles(T_PWE_NS, CLK_NS),
                                 maxInt(phaseCycles(T_AW_NS, CLK_NS) - 1,
                                        phaseCycles(T_SD_NS, CLK_NS) - 1));
  localparam int N_HOLD = maxInt(1, phaseCycles(T_WC_NS, CLK_NS) - 1 - N_PWE);
  localparam int N_TURN = phaseCycles(T_HZ_NS, CLK_NS);
  localparam int N_MAX  = maxInt(maxInt(N_RD, N_PWE), maxInt(N_HOLD, N_TURN));
  localparam int CNT_W  = (N_MAX > 1) ? $clog2(N_MAX) : 1;

  ctrlStrobe_t stb;

  sram_ctrl_fsm #(
    .N_RD  (N_RD),
    .N_PWE (N_PWE),
    .N_HOLD(N_HOLD),
    .N_TURN(N_TURN),
    .CNT_W (CNT_W)
  ) fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .stb     (stb)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqMask   (reqMask),
    .ramDqIn   (ramDqIn),
    .ramAddr   (ramAddr),
    .ramSelN   (ramSelN),
    .ramSelP   (ramSelP),
    .ramLaneN  (ramLaneN),
    .ramOutEnN (ramOutEnN),
    .ramWrEnN  (ramWrEnN),
    .ramDqOut  (ramDqOut),
    .ramDqDrive(ramDqDrive),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .wrDone    (wrDone)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramSelN,
  input logic              ramSelP,
  input logic [LANES-1:0]  ramLaneN,
  input logic              ramOutEnN,
  input logic              ramWrEnN,
  input logic              ramDqDrive,
  input logic              rdValid,
  input logic              wrDone
);

  // R1
  r1_idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (ramSelN && !ramSelP && (&ramLaneN) && ramOutEnN && ramWrEnN && !ramDqDrive));

  // R2
  r2_busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R3
  r3_read_addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ramOutEnN && !$past(ramOutEnN)) |-> ($stable(ramAddr) && $stable(ramLaneN)));

  // R4
  r4_rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R6
  r6_drive_selected_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramDqDrive |-> (!ramSelN && ramSelP && ramOutEnN));

  // R7
  r7_wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> !wrDone);

  // R8
  r8_turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramOutEnN) |=> (!ramDqDrive && ramSelN));

  // R10
  r10_no_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ramOutEnN |-> (ramWrEnN && !ramDqDrive));

  // R11
  r11_we_ends_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWrEnN) |-> (!ramSelN && ramSelP && $stable(ramLaneN) && ramDqDrive));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .LANES (LANES)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .ramAddr   (ramAddr),
  .ramSelN   (ramSelN),
  .ramSelP   (ramSelP),
  .ramLaneN  (ramLaneN),
  .ramOutEnN (ramOutEnN),
  .ramWrEnN  (ramWrEnN),
  .ramDqDrive(ramDqDrive),
  .rdValid   (rdValid),
  .wrDone    (wrDone)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

  localparam int CLK_NS   = 10;
  localparam int C_RC     = (55 + CLK_NS - 1) / CLK_NS;
  localparam int C_OE     = (25 + CLK_NS - 1) / CLK_NS;
  localparam int RD_CYC   = (C_RC > C_OE) ? C_RC : C_OE;
  localparam int C_PWE    = (40 + CLK_NS - 1) / CLK_NS;
  localparam int C_AWm1   = (40 + CLK_NS - 1) / CLK_NS - 1;
  localparam int C_SDm1   = (25 + CLK_NS - 1) / CLK_NS - 1;
  localparam int PWE_CYC  = (C_PWE > C_AWm1) ? ((C_PWE > C_SDm1) ? C_PWE : C_SDm1)
                                             : ((C_AWm1 > C_SDm1) ? C_AWm1 : C_SDm1);
  localparam int C_WC     = (55 + CLK_NS - 1) / CLK_NS;
  localparam int HOLD_CYC = (C_WC - 1 - PWE_CYC > 1) ? (C_WC - 1 - PWE_CYC) : 1;
  localparam int TURN_CYC = (18 + CLK_NS - 1) / CLK_NS;
  localparam logic [6:0] IDLE_PINS = 7'b1_0_11_1_1_0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic        wrDone;
  logic [19:0] ramAddr;
  logic        ramSelN, ramSelP, ramOutEnN, ramWrEnN, ramDqDrive;
  logic [1:0]  ramLaneN;
  logic [15:0] ramDqOut;
  logic [15:0] ramDqIn;

  int nChecks = 0;
  int nFail = 0;
  int modelErr = 0;
  bit finished = 1'b0;
  logic [15:0] mem [0:15];
  logic [15:0] shadow [0:15];

  always #(CLK_NS / 2) clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdValid(rdValid), .rdData(rdData), .wrDone(wrDone), .ramAddr(ramAddr),
    .ramSelN(ramSelN), .ramSelP(ramSelP), .ramLaneN(ramLaneN), .ramOutEnN(ramOutEnN),
    .ramWrEnN(ramWrEnN), .ramDqOut(ramDqOut), .ramDqDrive(ramDqDrive), .ramDqIn(ramDqIn)
  );

  // RAM model: writes while selected with write enable low, filler on idle lanes
  always @(negedge clk) begin
    if (rstN && !ramSelN && ramSelP && !ramWrEnN) begin
      if (!ramDqDrive) modelErr++;
      for (int l = 0; l < 2; l++)
        if (!ramLaneN[l]) mem[ramAddr[3:0]][l*8 +: 8] <= ramDqOut[l*8 +: 8];
    end
    if (rstN && !ramOutEnN && ramDqDrive) modelErr++;
  end

  always_comb begin
    for (int l = 0; l < 2; l++)
      ramDqIn[l*8 +: 8] = (!ramSelN && ramSelP && !ramOutEnN && ramWrEnN && !ramLaneN[l])
                          ? mem[ramAddr[3:0]][l*8 +: 8] : 8'hA5;
  end

  function automatic logic [6:0] pinsNow();
    return {ramSelN, ramSelP, ramLaneN, ramOutEnN, ramWrEnN, ramDqDrive};
  endfunction

  function automatic logic [19:0] addrOf(input int a);
    return {16'(a * 16'h1357 + 16'h0C80), 4'(a)};
  endfunction

  function automatic logic [15:0] dataOf(input int a, input int m);
    return 16'(a * 16'h02B3) ^ 16'(m * 16'h09E1) ^ 16'h4C1D;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge with the block idle; returns at the first idle negedge after.
  task automatic doWrite(input int a, input logic [15:0] d, input logic [1:0] m, input bit intrude);
    logic [19:0] ad;
    ad = addrOf(a);
    check("R2 ready before write", reqReady, 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = ad; reqWdata = d; reqMask = m;
    for (int i = 0; i < 1 + PWE_CYC + HOLD_CYC; i++) begin
      @(negedge clk);
      if (i == 0) reqValid = 1'b0;
      // R5 phase pins; R6 drive; R9 lanes
      check("R5 write pins", pinsNow(),
            {1'b0, 1'b1, ~m, 1'b1, (i >= 1 && i <= PWE_CYC) ? 1'b0 : 1'b1,
             (i <= PWE_CYC + 1) ? 1'b1 : 1'b0});
      check("R5 write address", ramAddr, ad);
      check("R6 write data", ramDqOut, d);
      check("R2 ready low in write", reqReady, 0);
      if (intrude && i == 2) begin
        reqValid = 1'b1; reqWrite = 1'b0; reqAddr = ad ^ 20'h00005; reqMask = 2'b11;
      end
      if (intrude && i == PWE_CYC + HOLD_CYC - 1) reqValid = 1'b0;
    end
    @(negedge clk);
    check("R7 write done", wrDone, 1);
    check("R1 idle after write", {pinsNow(), reqReady}, {IDLE_PINS, 1'b1});
    for (int l = 0; l < 2; l++)
      if (m[l]) shadow[a][l*8 +: 8] = d[l*8 +: 8];
    if (intrude) begin
      @(negedge clk);
      check("R2 held-off request ignored", {pinsNow(), wrDone}, {IDLE_PINS, 1'b0});
    end
  endtask

  task automatic doRead(input int a, input logic [1:0] m);
    logic [19:0] ad;
    logic [15:0] exp;
    ad = addrOf(a);
    exp = shadow[a] & {{8{m[1]}}, {8{m[0]}}};
    check("R2 ready before read", reqReady, 1);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = ad; reqMask = m;
    for (int i = 0; i < RD_CYC + TURN_CYC; i++) begin
      @(negedge clk);
      if (i == 0) reqValid = 1'b0;
      if (i < RD_CYC) begin
        check("R3 read pins", pinsNow(), {1'b0, 1'b1, ~m, 1'b0, 1'b1, 1'b0});
        check("R3 read address", ramAddr, ad);
        check("R4 no early valid", rdValid, 0);
      end else begin
        check("R8 turnaround pins", {pinsNow(), reqReady}, {IDLE_PINS, 1'b0});
        if (i == RD_CYC) begin
          check("R4 read valid", rdValid, 1);
          check("R4 R9 read data", rdData, exp);
        end else begin
          check("R4 valid single cycle", rdValid, 0);
        end
      end
    end
    @(negedge clk);
    check("R1 idle after read", {pinsNow(), reqReady, rdValid}, {IDLE_PINS, 1'b1, 1'b0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pins in reset", {pinsNow(), reqReady}, {IDLE_PINS, 1'b1});
    rstN = 1'b1;
    @(negedge clk);
    check("R1 pins after reset", {pinsNow(), reqReady, rdValid, wrDone},
          {IDLE_PINS, 1'b1, 1'b0, 1'b0});
    for (int a = 0; a < 16; a++) begin
      shadow[a] = '0;
      doWrite(a, dataOf(a, 7), 2'b11, 1'b0);
    end
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 4; m++) begin
        doWrite(a, dataOf(a, m), 2'(m), (a == 3 && m == 2));
        for (int mr = 0; mr < 4; mr++) doRead(a, 2'(mr));
      end
    end
    // back-to-back read after write and write after read on the same word
    doRead(9, 2'b11);
    doWrite(9, 16'hF00F, 2'b01, 1'b0);
    doRead(9, 2'b11);
    check("R10 bus conflict or undriven write", modelErr, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule